// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital side of a supply-voltage monitor. A comparator outside the block reports whether the supply sits above the reset threshold. The block keeps a one-byte control register on a simple special-function-register bus. The register holds an enable bit and shows a live status bit. The block waits out a turn-on settling time after the monitor is enabled. It combines all of this with a reset-source select bit from elsewhere in the chip to produce an active-low reset request. It also keeps two cause flags, so software can tell a monitor reset apart from a power-on reset or any other reset.

The power-on pulse `por_i` is the only input that clears the block's own state. Every other reset source arrives on `other_rst_i`, and the enable bit survives it. A state machine with five states drives the reset request:

- **OFF**: the monitor is disabled.
- **SETTLING**: the monitor is enabled but has not yet settled.
- **WATCH**: the monitor is settled and tracking the supply.
- **TRIP**: reset is held while the supply is low, or after a premature select.
- **HOLD**: the supply has recovered and a minimum width is being counted out.

The transitions are:

- OFF goes to SETTLING on enable.
- SETTLING goes to WATCH once settled, or to TRIP if selected earlier than that.
- WATCH goes to TRIP when selected and the supply is at or below threshold.
- TRIP goes to HOLD when the supply comes back.
- HOLD returns to TRIP if the supply dips again. When its count expires, it goes to WATCH if the monitor is settled, otherwise to SETTLING.
- Any state goes to OFF when the enable is cleared.

`rst_n_o` reflects the monitor's own request only.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: The control register answers at bus address 0xFF. Bit 7 is the enable (1 = on) and is read/write. Bit 6 is the read-only supply status. Writes to bits 6..0 and writes to any other address have no effect. A read of any other address returns 0x00. Read data is combinational while the read strobe is high.
- R2: While the monitor is enabled, bit 6 reads 1 when `vdd_above_i` is 1 and 0 when it is 0, in the same cycle.
- R3: While the monitor is disabled, bit 6 reads the comparator value sampled on the last clock edge at which the enable was still 1. A power-on clears this sampled value to 0.
- R4: A power-on sets the enable to 1, sets the power-on flag and clears the monitor flag. A pulse on `other_rst_i` leaves the enable unchanged.
- R5: The monitor counts as settled once SETTLE_CYC (default 100) clock edges have passed after the edge that set the enable. Clearing the enable restarts the count.
- R6: `rst_n_o` stays 1 whenever the monitor is disabled or not selected, whatever the supply does.
- R7: When the monitor is enabled, settled and selected, `rst_n_o` goes to 0 one cycle after the edge that samples the supply at or below threshold. It stays 0 as long as the supply stays low.
- R8: After the first edge that samples the supply above threshold again, `rst_n_o` stays 0 for HOLD_CYC (default 16) more edges. It returns to 1 after the next edge. A dip during this window restarts the window.
- R9: If the select is 1 while the monitor is enabled but not yet settled, a monitor reset is generated on the next edge.
- R10: The start of a monitor reset sets the monitor flag and clears the power-on flag. A pulse on `other_rst_i` clears both flags.
- R11: Clearing the enable during a monitor reset releases `rst_n_o` one edge after the edge that stores the cleared enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, active high, synchronous |
| other_rst_i | input | 1 | Pulse from any other reset source (software, pin) |
| vdd_above_i | input | 1 | Comparator output: 1 = supply above threshold |
| mon_sel_i | input | 1 | Monitor selected as a reset source |
| sfr_addr_i | input | ADDR_W | Register bus address |
| sfr_wr_i | input | 1 | Register bus write strobe |
| sfr_rd_i | input | 1 | Register bus read strobe |
| sfr_wdata_i | input | DATA_W | Register bus write data |
| sfr_rdata_o | output | DATA_W | Register bus read data |
| rst_n_o | output | 1 | Active-low reset request from the monitor |
| por_flag_o | output | 1 | Last reset came from power-on |
| mon_flag_o | output | 1 | Last reset came from the supply monitor |

## Verification
A wrong internal state in this block shows at the ports within one or two cycles.

- A settle counter that is off by one moves the edge at which a premature select still trips. The bench probes that edge from both sides.
- A hold counter of the wrong length moves the rising edge of `rst_n_o` after recovery by a whole cycle.
- A state machine left in the wrong state shows up either as a reset while the monitor is unselected or disabled, or as a missing reset on the cycle after a low supply.
- A corrupted enable or sampled-status register appears on the next read of bit 7 or bit 6.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    // Reset-request controller states
    typedef enum logic [2:0] {
        MON_OFF      = 3'd0,
        MON_SETTLING = 3'd1,
        MON_WATCH    = 3'd2,
        MON_TRIP     = 3'd3,
        MON_HOLD     = 3'd4
    } mon_state_e;

    // Control register field positions
    localparam int unsigned CSR_EN_BIT   = 7;
    localparam int unsigned CSR_STAT_BIT = 6;

endpackage

// File: rtl/supmon_csr.sv
module supmon_csr
    import supmon_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter int unsigned      DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'hFF
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              vdd_above_i,
    input  logic [ADDR_W-1:0] sfr_addr_i,
    input  logic              sfr_wr_i,
    input  logic              sfr_rd_i,
    input  logic [DATA_W-1:0] sfr_wdata_i,
    output logic [DATA_W-1:0] sfr_rdata_o,
    output logic              en_o
);

    logic en_q;
    logic stat_q;
    logic hit;
    logic status;
    logic reserved_unused;

    assign hit             = (sfr_addr_i == CSR_ADDR);
    assign reserved_unused = ^sfr_wdata_i[CSR_STAT_BIT:0];

    // Enable bit: set by power-on only, otherwise software owned
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            en_q <= 1'b1;
        end else if (sfr_wr_i && hit) begin
            en_q <= sfr_wdata_i[CSR_EN_BIT];
        end
    end

    // Sampled status, frozen while the monitor is off
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            stat_q <= 1'b0;
        end else if (en_q) begin
            stat_q <= vdd_above_i;
        end
    end

    assign status = en_q ? vdd_above_i : stat_q;

    always_comb begin
        sfr_rdata_o = '0;
        if (sfr_rd_i && hit) begin
            sfr_rdata_o[CSR_EN_BIT]   = en_q;
            sfr_rdata_o[CSR_STAT_BIT] = status;
        end
    end

    assign en_o = en_q;

    // R1: a write to the register stores bit 7 as the new enable
    assert_wr_en_R1: assert property (@(posedge clk_i) disable iff (por_i)
        (sfr_wr_i && hit) |=> (en_q == $past(sfr_wdata_i[CSR_EN_BIT])));

    // R1: traffic elsewhere leaves the enable alone
    assert_miss_keeps_en_R1: assert property (@(posedge clk_i) disable iff (por_i)
        !(sfr_wr_i && hit) |=> $stable(en_q));

    // R2: enabled monitor reads the live comparator
    assert_status_live_R2: assert property (@(posedge clk_i) disable iff (por_i)
        (en_q && sfr_rd_i && hit) |-> (sfr_rdata_o[CSR_STAT_BIT] == vdd_above_i));

    // R3: sampled status is frozen while disabled
    assert_status_frozen_R3: assert property (@(posedge clk_i) disable iff (por_i)
        !en_q |=> (stat_q == $past(stat_q)));

endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
    parameter int unsigned SETTLE_CYC = 100,
    localparam int unsigned CW        = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic en_i,
    output logic settled_o
);

    logic [CW-1:0] cnt_q;
    logic          settled_q;
    logic          last_tick;

    assign last_tick = (cnt_q == CW'(SETTLE_CYC - 1));

    always_ff @(posedge clk_i) begin
        if (por_i || !en_i) begin
            cnt_q     <= '0;
            settled_q <= 1'b0;
        end else if (!settled_q) begin
            if (last_tick) begin
                settled_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign settled_o = settled_q;

    // R5: a disabled monitor is never settled on the next cycle
    assert_settle_clear_R5: assert property (@(posedge clk_i) disable iff (por_i)
        !en_i |=> !settled_q);

    // R5: once settled, it stays settled while enabled
    assert_settle_keep_R5: assert property (@(posedge clk_i) disable iff (por_i)
        (settled_q && en_i) |=> settled_q);

    // R5: the count never runs past its limit
    assert_settle_bound_R5: assert property (@(posedge clk_i) disable iff (por_i)
        cnt_q < CW'(SETTLE_CYC));

endmodule

// File: rtl/supmon_fsm.sv
module supmon_fsm
    import supmon_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 16,
    localparam int unsigned HW      = $clog2(HOLD_CYC + 1)
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic en_i,
    input  logic settled_i,
    input  logic sel_i,
    input  logic above_i,
    output logic rst_req_o,
    output logic trip_evt_o
);

    mon_state_e    state_q;
    mon_state_e    state_d;
    logic [HW-1:0] hcnt_q;
    logic          hold_done;

    assign hold_done = (hcnt_q == HW'(HOLD_CYC - 1));

    // State register
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            state_q <= MON_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Minimum-width counter, only runs in HOLD
    always_ff @(posedge clk_i) begin
        if (por_i || (state_q != MON_HOLD)) begin
            hcnt_q <= '0;
        end else if (!hold_done) begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF: begin
                if (en_i) state_d = MON_SETTLING;
            end
            MON_SETTLING: begin
                if (!en_i)          state_d = MON_OFF;
                else if (settled_i) state_d = MON_WATCH;
                else if (sel_i)     state_d = MON_TRIP;
            end
            MON_WATCH: begin
                if (!en_i)                  state_d = MON_OFF;
                else if (!settled_i)        state_d = MON_SETTLING;
                else if (sel_i && !above_i) state_d = MON_TRIP;
            end
            MON_TRIP: begin
                if (!en_i)        state_d = MON_OFF;
                else if (above_i) state_d = MON_HOLD;
            end
            MON_HOLD: begin
                if (!en_i)          state_d = MON_OFF;
                else if (!above_i)  state_d = MON_TRIP;
                else if (hold_done) state_d = settled_i ? MON_WATCH : MON_SETTLING;
            end
            default: state_d = MON_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        rst_req_o  = (state_q == MON_TRIP) || (state_q == MON_HOLD);
        trip_evt_o = (state_d == MON_TRIP) &&
                     (state_q != MON_TRIP) && (state_q != MON_HOLD);
    end

    // R6: no request can follow a disabled cycle
    assert_off_no_req_R6: assert property (@(posedge clk_i) disable iff (por_i)
        !en_i |=> !rst_req_o);

    // R6: an unselected monitor outside reset stays quiet
    assert_unsel_no_req_R6: assert property (@(posedge clk_i) disable iff (por_i)
        ((state_q == MON_WATCH) && !sel_i) |=> !rst_req_o);

    // R7: low supply while armed trips on the next cycle
    assert_trip_on_low_R7: assert property (@(posedge clk_i) disable iff (por_i)
        ((state_q == MON_WATCH) && en_i && settled_i && sel_i && !above_i) |=> rst_req_o);

    // R7: reset stays while the supply stays low
    assert_trip_stays_R7: assert property (@(posedge clk_i) disable iff (por_i)
        ((state_q == MON_TRIP) && en_i && !above_i) |=> (state_q == MON_TRIP));

    // R8: an enabled release only happens at the end of the hold window
    assert_min_width_R8: assert property (@(posedge clk_i) disable iff (por_i)
        ($fell(rst_req_o) && $past(en_i)) |-> $past(hold_done));

    // R9: select before settling trips on the next cycle
    assert_premature_R9: assert property (@(posedge clk_i) disable iff (por_i)
        ((state_q == MON_SETTLING) && en_i && !settled_i && sel_i) |=> (state_q == MON_TRIP));

    // R11: disabling during reset goes straight to OFF
    assert_disable_release_R11: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_req_o && !en_i) |=> (state_q == MON_OFF));

endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR   = 8'hFF,
    parameter int unsigned       SETTLE_CYC = 100,
    parameter int unsigned       HOLD_CYC   = 16
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              other_rst_i,
    input  logic              vdd_above_i,
    input  logic              mon_sel_i,
    input  logic [ADDR_W-1:0] sfr_addr_i,
    input  logic              sfr_wr_i,
    input  logic              sfr_rd_i,
    input  logic [DATA_W-1:0] sfr_wdata_i,
    output logic [DATA_W-1:0] sfr_rdata_o,
    output logic              rst_n_o,
    output logic              por_flag_o,
    output logic              mon_flag_o
);

    logic en_w;
    logic settled_w;
    logic rst_req_w;
    logic trip_evt_w;
    logic por_flag_q;
    logic mon_flag_q;

    supmon_csr #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CSR_ADDR (CSR_ADDR)
    ) u_csr (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .vdd_above_i (vdd_above_i),
        .sfr_addr_i  (sfr_addr_i),
        .sfr_wr_i    (sfr_wr_i),
        .sfr_rd_i    (sfr_rd_i),
        .sfr_wdata_i (sfr_wdata_i),
        .sfr_rdata_o (sfr_rdata_o),
        .en_o        (en_w)
    );

    supmon_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .en_i      (en_w),
        .settled_o (settled_w)
    );

    supmon_fsm #(
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .en_i       (en_w),
        .settled_i  (settled_w),
        .sel_i      (mon_sel_i),
        .above_i    (vdd_above_i),
        .rst_req_o  (rst_req_w),
        .trip_evt_o (trip_evt_w)
    );

    // Reset-cause flags
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            por_flag_q <= 1'b1;
            mon_flag_q <= 1'b0;
        end else if (trip_evt_w) begin
            por_flag_q <= 1'b0;
            mon_flag_q <= 1'b1;
        end else if (other_rst_i) begin
            por_flag_q <= 1'b0;
            mon_flag_q <= 1'b0;
        end
    end

    assign rst_n_o    = !rst_req_w;
    assign por_flag_o = por_flag_q;
    assign mon_flag_o = mon_flag_q;

    // R4: other reset sources do not touch the enable
    assert_en_survives_R4: assert property (@(posedge clk_i) disable iff (por_i)
        (other_rst_i && !(sfr_wr_i && (sfr_addr_i == CSR_ADDR))) |=> $stable(en_w));

    // R10: a monitor reset marks its own cause
    assert_mon_cause_R10: assert property (@(posedge clk_i) disable iff (por_i)
        trip_evt_w |=> (mon_flag_o && !por_flag_o));

    // R10: the two cause flags are never both set
    assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (por_i)
        !(mon_flag_o && por_flag_o));

endmodule

// File: tb/supmon_rst_ctrl_test.sv
module supmon_rst_ctrl_test;

    localparam int SETTLE = 100;
    localparam int HOLD   = 16;

    logic       clk = 1'b0;
    logic       por, orst, above, sel, wr, rd;
    logic [7:0] addr, wdata, rdata;
    logic       rst_n, porf, monf;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    supmon_rst_ctrl #(
        .SETTLE_CYC (SETTLE),
        .HOLD_CYC   (HOLD)
    ) uut (
        .clk_i       (clk),
        .por_i       (por),
        .other_rst_i (orst),
        .vdd_above_i (above),
        .mon_sel_i   (sel),
        .sfr_addr_i  (addr),
        .sfr_wr_i    (wr),
        .sfr_rd_i    (rd),
        .sfr_wdata_i (wdata),
        .sfr_rdata_o (rdata),
        .rst_n_o     (rst_n),
        .por_flag_o  (porf),
        .mon_flag_o  (monf)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_csr(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1;
        d = rdata;
        rd = 1'b0; addr = 8'h00;
    endtask

    task automatic wr_csr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 8'h00;
    endtask

    function automatic logic [7:0] exp_csr(input logic en, input logic st);
        return {en, st, 6'b0};
    endfunction

    logic [7:0]  d;
    logic [7:0]  a;
    logic        en_m, hold_m;
    int unsigned op;
    int unsigned seed_init;

    initial begin
        por = 1'b1; orst = 1'b0; above = 1'b1; sel = 1'b0;
        wr = 1'b0; rd = 1'b0; addr = 8'h00; wdata = 8'h00;
        seed_init = $urandom(32'd20417);
        cyc(3);
        por = 1'b0;

        // Reset state
        check("R4 por flag after power-on", {7'b0, porf}, 8'h01);
        check("R10 mon flag after power-on", {7'b0, monf}, 8'h00);
        check("R6 rst_n after power-on", {7'b0, rst_n}, 8'h01);
        rd_csr(8'hFF, d);
        check("R4 enable set by power-on", d & 8'hC0, exp_csr(1'b1, 1'b1));
        rd_csr(8'h10, d);
        check("R1 other address reads zero", d, 8'h00);
        wr_csr(8'h10, 8'h00);
        rd_csr(8'hFF, d);
        check("R1 write elsewhere ignored", d & 8'h80, 8'h80);

        cyc(SETTLE + 5);

        // Unselected monitor, supply low
        above = 1'b0;
        cyc(5);
        check("R6 unselected no reset", {7'b0, rst_n}, 8'h01);
        rd_csr(8'hFF, d);
        check("R2 live status low", d & 8'hC0, exp_csr(1'b1, 1'b0));
        above = 1'b1;
        rd_csr(8'hFF, d);
        check("R2 live status high", d & 8'hC0, exp_csr(1'b1, 1'b1));

        // Armed trip
        sel = 1'b1;
        cyc(3);
        check("R7 no reset while above", {7'b0, rst_n}, 8'h01);
        above = 1'b0;
        cyc(1);
        check("R7 reset one cycle after low", {7'b0, rst_n}, 8'h00);
        cyc(20);
        check("R7 reset held while low", {7'b0, rst_n}, 8'h00);
        check("R10 mon flag set", {7'b0, monf}, 8'h01);
        check("R10 por flag cleared", {7'b0, porf}, 8'h00);

        // Minimum width
        above = 1'b1;
        cyc(HOLD);
        check("R8 still low at end of window", {7'b0, rst_n}, 8'h00);
        cyc(1);
        check("R8 released after window", {7'b0, rst_n}, 8'h01);

        // Dip during hold restarts the window
        above = 1'b0; cyc(1);
        above = 1'b1; cyc(8);
        above = 1'b0; cyc(1);
        check("R8 dip re-trips", {7'b0, rst_n}, 8'h00);
        above = 1'b1;
        cyc(HOLD);
        check("R8 restarted window still low", {7'b0, rst_n}, 8'h00);
        cyc(1);
        check("R8 restarted window releases", {7'b0, rst_n}, 8'h01);

        // Other reset source
        orst = 1'b1; cyc(1); orst = 1'b0;
        check("R10 other reset clears mon flag", {7'b0, monf}, 8'h00);
        check("R10 other reset keeps por flag clear", {7'b0, porf}, 8'h00);
        rd_csr(8'hFF, d);
        check("R4 enable survives other reset", d & 8'h80, 8'h80);

        // Disable during reset
        above = 1'b0; cyc(1);
        check("R7 trip before disable", {7'b0, rst_n}, 8'h00);
        wr_csr(8'hFF, 8'h00);
        cyc(1);
        check("R11 disable releases reset", {7'b0, rst_n}, 8'h01);
        above = 1'b1;
        rd_csr(8'hFF, d);
        check("R3 frozen status low", d & 8'hC0, exp_csr(1'b0, 1'b0));
        above = 1'b0; cyc(10);
        check("R6 disabled no reset", {7'b0, rst_n}, 8'h01);
        above = 1'b1;
        rd_csr(8'hFF, d);
        check("R3 frozen status unchanged", d & 8'hC0, exp_csr(1'b0, 1'b0));

        // Premature select
        wr_csr(8'hFF, 8'h80);
        cyc(1);
        check("R9 no reset before settling state", {7'b0, rst_n}, 8'h01);
        cyc(1);
        check("R9 premature select resets", {7'b0, rst_n}, 8'h00);
        check("R10 premature reset sets mon flag", {7'b0, monf}, 8'h01);
        cyc(150);
        check("R9 reset ends once settled", {7'b0, rst_n}, 8'h01);

        // Settle boundary, count restart on disable
        sel = 1'b0;
        cyc(60);
        wr_csr(8'hFF, 8'h00);
        wr_csr(8'hFF, 8'h80);
        cyc(SETTLE - 1);
        sel = 1'b1;
        cyc(1);
        check("R5 last unsettled cycle trips", {7'b0, rst_n}, 8'h00);
        sel = 1'b0;
        cyc(40);
        check("R8 recovers after boundary trip", {7'b0, rst_n}, 8'h01);
        wr_csr(8'hFF, 8'h00);
        wr_csr(8'hFF, 8'h80);
        cyc(SETTLE);
        sel = 1'b1;
        cyc(3);
        check("R5 first settled cycle no trip", {7'b0, rst_n}, 8'h01);
        sel = 1'b0;

        // Power-on mid-run
        wr_csr(8'hFF, 8'h00);
        rd_csr(8'hFF, d);
        check("R1 enable cleared by write", d & 8'h80, 8'h00);
        por = 1'b1; cyc(2); por = 1'b0;
        rd_csr(8'hFF, d);
        check("R4 power-on re-enables", d & 8'h80, 8'h80);
        check("R4 power-on sets por flag", {7'b0, porf}, 8'h01);
        check("R10 power-on clears mon flag", {7'b0, monf}, 8'h00);

        // Random register traffic, unselected
        en_m = 1'b1; hold_m = 1'b0;
        for (int i = 0; i < 400; i++) begin
            op    = $urandom_range(0, 3);
            d     = 8'($urandom);
            a     = 8'($urandom_range(0, 254));
            above = 1'($urandom);
            if (op == 0) begin
                rd_csr(8'hFF, wdata);
                check("R2 R3 random read", wdata & 8'hC0,
                      exp_csr(en_m, en_m ? above : hold_m));
            end
            check("R6 random no reset", {7'b0, rst_n}, 8'h01);
            if (op == 1) begin
                addr = 8'hFF; wdata = d; wr = 1'b1;
            end else if (op == 2) begin
                addr = a; wdata = d; wr = 1'b1;
            end
            @(negedge clk);
            wr = 1'b0; addr = 8'h00;
            if (en_m) hold_m = above;
            if (op == 1) en_m = d[7];
        end
        rd_csr(8'hFF, d);
        check("R1 final enable", d & 8'h80, {en_m, 7'b0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule